// File: doc/BRIEF.md
# Signed Integer Divider with Bus Registers

This block is a signed integer divider that software drives through a word-wide register bus. Software loads a 64-bit dividend and a 64-bit divisor as pairs of 32-bit words, then picks an operand width mode in a control word. Every write to an operand or to the control word starts a new division from the values held at that moment. The block works one quotient bit per clock through a shift-and-subtract engine. It then posts a signed quotient and remainder, clears a busy flag, and shows division faults in an error flag.

The number of cycles a division takes depends only on the mode. A 32-bit division finishes in about half the time of a 64-bit one. Two fault cases return defined values: a zero divisor, and the most negative 64-bit dividend divided by minus one. Software polls the busy bit and then reads the result words.

Top module: `sdiv_mmio`

## Requirements
- R1: After reset every register reads as zero, including the control word.
- R2: Word addresses are fixed: control 0, dividend 2 (low) and 3 (high), divisor 4 (low) and 5 (high), quotient 6 (low) and 7 (high), remainder 8 (low) and 9 (high). The low half of each 64-bit value sits at the lower address. In the control word, bits [1:0] hold the mode, bit 14 is the error flag, bit 15 is the busy flag, and all other bits read zero.
- R3: In mode 0, both the dividend and the divisor are taken as their low 32 bits, sign-extended to 64 bits.
- R4: In modes 1 and 3, the dividend is used as a full 64-bit value and the divisor is its low 32 bits, sign-extended.
- R5: In mode 2, the full 64-bit dividend is divided by the full 64-bit divisor.
- R6: The quotient is truncated toward zero. A non-zero remainder has the sign of the dividend.
- R7: A write to the control word, the dividend or the divisor sets the busy flag. With no further write, busy reads 1 for exactly 34 clock cycles in mode 0 and exactly 66 clock cycles in the other modes, counted from the write edge. It then reads 0 and the results are valid.
- R8: A write that lands while busy is set restarts the division from the current operands. The full latency counts again from that write, and the result reflects the latest operands only.
- R9: For a zero divisor (after mode formatting), the error flag is set. The remainder receives the formatted dividend. The quotient is 1 when that dividend is negative and 0 otherwise.
- R10: When the formatted dividend is the most negative 64-bit value and the divisor is -1, the error flag is set, the quotient equals the dividend, and the remainder keeps its previous value.
- R11: A division with neither fault clears the error flag.
- R12: Writes to the quotient and remainder addresses have no effect. They change no result and do not set busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the word at addr |
| addr | input | 4 | Word address for both reads and writes |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for the word at addr, combinational |

## Verification
The hardest situation to reach from the ports is a restart in the middle of a running division. The new operands must replace the old ones completely, with nothing of the abandoned run reaching the result registers. The stimulus starts a 64-bit division, waits a random number of cycles short of completion, and then rewrites the divisor. It checks that busy stays high for a full latency measured from that later write, and that the results match only the new operand set. The two fault cases are reached with directed operands that the random stream would almost never produce. These are the most negative dividend over -1 in two modes, and zero divisors produced only by the mode's truncation of a non-zero upper word.

// File: rtl/sdiv_pkg.sv
`timescale 1ns/1ps
package sdiv_pkg;
    localparam int BUS_W    = 32;
    localparam int BUSY_BIT = 15;
    localparam int ERR_BIT  = 14;

    typedef enum logic [3:0] {
        RA_CTRL   = 4'd0,
        RA_NUM_LO = 4'd2,
        RA_NUM_HI = 4'd3,
        RA_DEN_LO = 4'd4,
        RA_DEN_HI = 4'd5,
        RA_QUO_LO = 4'd6,
        RA_QUO_HI = 4'd7,
        RA_REM_LO = 4'd8,
        RA_REM_HI = 4'd9
    } reg_addr_e;

    typedef enum logic [1:0] {
        MD_S32_S32 = 2'd0,
        MD_S64_S32 = 2'd1,
        MD_S64_S64 = 2'd2,
        MD_S64_S32B = 2'd3
    } div_mode_e;
endpackage

// File: rtl/sdiv_prep.sv
`timescale 1ns/1ps
module sdiv_prep #(
    parameter int DATA_W  = 64,
    parameter int SHORT_W = 32
) (
    input  logic [1:0]        mode_i,
    input  logic [DATA_W-1:0] num_raw_i,
    input  logic [DATA_W-1:0] den_raw_i,
    output logic [DATA_W-1:0] num_eff_o,
    output logic [DATA_W-1:0] num_mag_o,
    output logic [DATA_W-1:0] den_mag_o,
    output logic              num_neg_o,
    output logic              quo_neg_o,
    output logic              div_zero_o,
    output logic              ovf_o,
    output logic              short_o
);
    import sdiv_pkg::*;
    localparam int EXT_W = DATA_W - SHORT_W;
    localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};

    logic [DATA_W-1:0] num_sx, den_sx, den_eff;
    logic              den_neg;

    always_comb begin
        num_sx  = {{EXT_W{num_raw_i[SHORT_W-1]}}, num_raw_i[SHORT_W-1:0]};
        den_sx  = {{EXT_W{den_raw_i[SHORT_W-1]}}, den_raw_i[SHORT_W-1:0]};
        short_o = (mode_i == MD_S32_S32);
        // R3 R4 R5 operand shaping by mode
        num_eff_o = short_o ? num_sx : num_raw_i;
        den_eff   = (mode_i == MD_S64_S64) ? den_raw_i : den_sx;
        num_neg_o = num_eff_o[DATA_W-1];
        den_neg   = den_eff[DATA_W-1];
        num_mag_o = num_neg_o ? (~num_eff_o + 1'b1) : num_eff_o;
        den_mag_o = den_neg ? (~den_eff + 1'b1) : den_eff;
        quo_neg_o = num_neg_o ^ den_neg;
        div_zero_o = (den_eff == '0);
        ovf_o      = (num_eff_o == MOST_NEG) && (den_eff == '1);
    end
endmodule

// File: rtl/sdiv_engine.sv
`timescale 1ns/1ps
module sdiv_engine #(
    parameter int DATA_W  = 64,
    parameter int SHORT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              short_i,
    input  logic [DATA_W-1:0] num_mag_i,
    input  logic [DATA_W-1:0] den_mag_i,
    output logic              busy_o,
    output logic [DATA_W-1:0] quo_o,
    output logic [DATA_W-1:0] rem_o
);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam int PRE_SHIFT = DATA_W - SHORT_W;
    localparam logic [CNT_W-1:0] LONG_STEPS  = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] SHORT_STEPS = CNT_W'(SHORT_W);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] quo;
        logic [DATA_W-1:0] rem;
        logic [DATA_W-1:0] den;
    } eng_t;

    eng_t st_q, st_d;
    logic [DATA_W+1:0] trial;

    always_comb begin
        st_d  = st_q;
        trial = {1'b0, st_q.rem, st_q.quo[DATA_W-1]} - {2'b00, st_q.den};
        if (start_i) begin
            st_d.cnt = short_i ? SHORT_STEPS : LONG_STEPS;
            st_d.quo = short_i ? (num_mag_i << PRE_SHIFT) : num_mag_i;
            st_d.rem = '0;
            st_d.den = den_mag_i;
        end else if (st_q.cnt != '0) begin
            if (!trial[DATA_W+1]) begin
                st_d.rem = trial[DATA_W-1:0];
                st_d.quo = {st_q.quo[DATA_W-2:0], 1'b1};
            end else begin
                st_d.rem = {st_q.rem[DATA_W-2:0], st_q.quo[DATA_W-1]};
                st_d.quo = {st_q.quo[DATA_W-2:0], 1'b0};
            end
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o = (st_q.cnt != '0);
    assign quo_o  = st_q.quo;
    assign rem_o  = st_q.rem;

    // R7: a load always leads to a running engine on the next cycle
    a_r7_start_runs: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> busy_o);
    // R6: a finished unsigned division leaves a remainder below the divisor
    a_r6_rem_below_den: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy_o) && st_q.den != '0) |-> (st_q.rem < st_q.den));
endmodule

// File: rtl/sdiv_mmio.sv
`timescale 1ns/1ps
module sdiv_mmio #(
    parameter int DATA_W  = 64,
    parameter int SHORT_W = 32,
    parameter int ADDR_W  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [sdiv_pkg::BUS_W-1:0] wr_data,
    output logic [sdiv_pkg::BUS_W-1:0] rd_data
);
    import sdiv_pkg::*;
    localparam int HW = BUS_W;

    typedef struct packed {
        logic [1:0]        mode;
        logic [DATA_W-1:0] num;
        logic [DATA_W-1:0] den;
        logic [DATA_W-1:0] quo;
        logic [DATA_W-1:0] rem;
        logic              err;
        logic              pending;
        logic              start;
    } regs_t;

    regs_t st_q, st_d;

    logic [DATA_W-1:0] num_eff, num_mag, den_mag, eng_quo, eng_rem;
    logic num_neg, quo_neg, div_zero, ovf, short_md, eng_busy;
    logic op_write, commit;

    sdiv_prep #(.DATA_W(DATA_W), .SHORT_W(SHORT_W)) prep_i (
        .mode_i(st_q.mode), .num_raw_i(st_q.num), .den_raw_i(st_q.den),
        .num_eff_o(num_eff), .num_mag_o(num_mag), .den_mag_o(den_mag),
        .num_neg_o(num_neg), .quo_neg_o(quo_neg), .div_zero_o(div_zero),
        .ovf_o(ovf), .short_o(short_md)
    );

    sdiv_engine #(.DATA_W(DATA_W), .SHORT_W(SHORT_W)) eng_i (
        .clk(clk), .rst_n(rst_n), .start_i(st_q.start), .short_i(short_md),
        .num_mag_i(num_mag), .den_mag_i(den_mag),
        .busy_o(eng_busy), .quo_o(eng_quo), .rem_o(eng_rem)
    );

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        op_write   = wr_en && (addr == RA_CTRL   || addr == RA_NUM_LO ||
                               addr == RA_NUM_HI || addr == RA_DEN_LO ||
                               addr == RA_DEN_HI);
        if (wr_en) begin
            case (addr)
                RA_CTRL:   st_d.mode           = wr_data[1:0];
                RA_NUM_LO: st_d.num[HW-1:0]     = wr_data;
                RA_NUM_HI: st_d.num[DATA_W-1:HW] = wr_data;
                RA_DEN_LO: st_d.den[HW-1:0]     = wr_data;
                RA_DEN_HI: st_d.den[DATA_W-1:HW] = wr_data;
                default: ;
            endcase
        end
        if (op_write) begin
            st_d.start   = 1'b1;
            st_d.pending = 1'b1;
        end
        commit = st_q.pending && !st_q.start && !eng_busy && !op_write;
        if (commit) begin
            st_d.pending = 1'b0;
            if (div_zero) begin
                st_d.err = 1'b1;
                st_d.rem = num_eff;
                st_d.quo = {{(DATA_W-1){1'b0}}, num_neg};
            end else if (ovf) begin
                st_d.err = 1'b1;
                st_d.quo = num_eff;
            end else begin
                st_d.err = 1'b0;
                st_d.quo = quo_neg ? (~eng_quo + 1'b1) : eng_quo;
                st_d.rem = num_neg ? (~eng_rem + 1'b1) : eng_rem;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_data = '0;
        case (addr)
            RA_CTRL: begin
                rd_data[1:0]    = st_q.mode;
                rd_data[ERR_BIT]  = st_q.err;
                rd_data[BUSY_BIT] = st_q.pending;
            end
            RA_NUM_LO: rd_data = st_q.num[HW-1:0];
            RA_NUM_HI: rd_data = st_q.num[DATA_W-1:HW];
            RA_DEN_LO: rd_data = st_q.den[HW-1:0];
            RA_DEN_HI: rd_data = st_q.den[DATA_W-1:HW];
            RA_QUO_LO: rd_data = st_q.quo[HW-1:0];
            RA_QUO_HI: rd_data = st_q.quo[DATA_W-1:HW];
            RA_REM_LO: rd_data = st_q.rem[HW-1:0];
            RA_REM_HI: rd_data = st_q.rem[DATA_W-1:HW];
            default: rd_data = '0;
        endcase
    end

    // R7: operand or control writes raise busy on the next cycle
    a_r7_write_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        op_write |=> st_q.pending);
    // R9: zero divisor reports an error
    a_r9_zero_flags_err: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && div_zero) |=> st_q.err);
    // R10: overflow leaves the remainder untouched
    a_r10_ovf_keeps_rem: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !div_zero && ovf) |=> ($stable(st_q.rem) && st_q.err));
    // R11: a clean division clears the error flag
    a_r11_clean_clears_err: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !div_zero && !ovf) |=> !st_q.err);
    // R12: results only move at completion
    a_r12_results_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(st_q.quo) && $stable(st_q.rem)));
endmodule

// File: tb/sdiv_mmio_tb_top.sv
`timescale 1ns/1ps
module sdiv_mmio_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = 4'd0;
    logic [31:0] wr_data = 32'd0;
    logic [31:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [63:0] exp_rem = 64'd0;

    always #2.5 clk = ~clk;

    sdiv_mmio dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
                     .wr_data(wr_data), .rd_data(rd_data));

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic rd64(input logic [3:0] a, output logic [63:0] d);
        logic [31:0] lo, hi;
        rd(a, lo);
        rd(a + 4'd1, hi);
        d = {hi, lo};
    endtask

    function automatic logic [63:0] sx(input logic [63:0] v);
        return {{32{v[31]}}, v[31:0]};
    endfunction

    // R3 R4 R5 R6 R9 R10 R11 reference
    task automatic model(input logic [1:0] m, input logic [63:0] n, input logic [63:0] d,
                         output logic [63:0] q, output logic [63:0] r, output logic e);
        logic signed [63:0] ne, de;
        ne = (m == 2'd0) ? sx(n) : n;
        de = (m == 2'd2) ? d : sx(d);
        if (de == 0) begin
            e = 1'b1; r = ne; q = ne[63] ? 64'd1 : 64'd0;
        end else if (ne == 64'h8000_0000_0000_0000 && de == -64'sd1) begin
            e = 1'b1; q = ne; r = exp_rem;
        end else begin
            e = 1'b0; q = ne / de; r = ne % de;
        end
    endtask

    task automatic wait_idle();
        logic [31:0] c;
        for (int i = 0; i < 200; i++) begin
            rd(4'd0, c);
            if (!c[15]) break;
            @(negedge clk);
        end
    endtask

    task automatic check_result(input string req, input logic [1:0] m,
                                input logic [63:0] n, input logic [63:0] d);
        logic [63:0] q, r, aq, ar;
        logic e;
        logic [31:0] c;
        model(m, n, d, q, r, e);
        rd64(4'd6, aq);
        rd64(4'd8, ar);
        rd(4'd0, c);
        chk({req, " quotient"}, aq, q);
        chk({req, " remainder"}, ar, r);
        chk({req, " error flag"}, {63'd0, c[14]}, {63'd0, e});
        exp_rem = r;
    endtask

    // R7 latency: busy 1 at LAT-1 cycles after write edge, 0 at LAT
    task automatic check_latency(input logic [1:0] m);
        logic [31:0] c;
        int lat;
        lat = (m == 2'd0) ? 34 : 66;
        rd(4'd0, c);
        chk("R7 busy right after write", {63'd0, c[15]}, 64'd1);
        repeat (lat - 1) @(negedge clk);
        rd(4'd0, c);
        chk("R7 busy one cycle before done", {63'd0, c[15]}, 64'd1);
        @(negedge clk);
        rd(4'd0, c);
        chk("R7 busy cleared at latency", {63'd0, c[15]}, 64'd0);
    endtask

    task automatic run_op(input string req, input logic [1:0] m, input logic [63:0] n,
                          input logic [63:0] d, input bit lat_chk);
        wr(4'd0, {30'd0, m});
        wr(4'd2, n[31:0]);
        wr(4'd3, n[63:32]);
        wr(4'd4, d[31:0]);
        wr(4'd5, d[63:32]);
        if (lat_chk) check_latency(m);
        else wait_idle();
        check_result(req, m, n, d);
    endtask

    function automatic logic [63:0] rnd_op(input int shape);
        logic [63:0] v;
        v = {$urandom, $urandom};
        case (shape)
            1: v = 64'($signed($urandom % 200) - 100);
            2: v = sx({32'd0, $urandom});
            default: ;
        endcase
        return v;
    endfunction

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] c;
        logic [63:0] v;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 R2 reset state across the map
        for (int a = 0; a < 10; a++) begin
            rd(4'(a), c);
            chk("R1 reset value", {32'd0, c}, 64'd0);
        end
        // R3 directed mode 0 with junk in upper words
        run_op("R3 R6 mode0 -7/2", 2'd0, 64'h1234_5678_FFFF_FFF9, 64'hABCD_0000_0000_0002, 1'b1);
        run_op("R3 mode0 min32/-1", 2'd0, 64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF, 1'b0);
        // R4 R5
        run_op("R4 mode1 64/32", 2'd1, 64'h8765_4321_0FED_CBA9, 64'h7777_7777_FFFF_FFFD, 1'b1);
        run_op("R4 mode3 64/32", 2'd3, 64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_0000_0007, 1'b0);
        run_op("R5 R6 mode2 64/64", 2'd2, 64'hF000_0000_0000_0001, 64'h0000_0001_0000_0003, 1'b1);
        // R9 zero divisor, positive and negative, truncation-made zero
        run_op("R9 zero divisor neg", 2'd2, 64'hFFFF_FFFF_FFFF_FF00, 64'd0, 1'b0);
        run_op("R11 clean clears error", 2'd2, 64'd100, 64'd7, 1'b0);
        run_op("R9 zero divisor truncated", 2'd1, 64'h0000_0000_0000_0055, 64'h5555_5555_0000_0000, 1'b0);
        // R10 overflow in two modes, remainder kept
        run_op("R10 overflow mode2", 2'd2, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
        run_op("R10 overflow mode1", 2'd1, 64'h8000_0000_0000_0000, 64'h0000_0000_FFFF_FFFF, 1'b0);
        run_op("R11 clean after overflow", 2'd0, 64'd9, 64'd4, 1'b0);
        // R12 writes to result words ignored
        wr(4'd6, 32'hDEAD_BEEF);
        wr(4'd9, 32'hCAFE_F00D);
        rd(4'd0, c);
        chk("R12 result write no busy", {63'd0, c[15]}, 64'd0);
        rd64(4'd6, v);
        chk("R12 quotient untouched", v, 64'd2);
        rd64(4'd8, v);
        chk("R12 remainder untouched", v, 64'd1);
        // R8 restart mid-run
        for (int k = 0; k < 4; k++) begin
            logic [63:0] n, d;
            n = rnd_op(0); d = rnd_op(2);
            wr(4'd0, 32'd2);
            wr(4'd2, n[31:0]); wr(4'd3, n[63:32]);
            wr(4'd4, 32'd3);
            repeat (5 + ($urandom % 50)) @(negedge clk);
            wr(4'd4, d[31:0]);
            wr(4'd5, d[63:32]);
            check_latency(2'd2);
            check_result("R8 restart uses new operands", 2'd2, n, d);
        end
        // random mix, R3 R4 R5 R6
        for (int k = 0; k < 60; k++) begin
            logic [1:0] m;
            m = 2'($urandom % 4);
            run_op("R6 random", m, rnd_op(int'($urandom % 3)), rnd_op(int'($urandom % 3)),
                   (k % 10) == 0);
        end
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule